// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block buffers 24-bit audio samples for one direction of one port of a serial audio interface. A processor reaches it through three registers: control, status and data. The serial engine on the far side takes or delivers one sample per strobe. Built for transmit, the processor pushes samples by writing the data register and the serial strobe pops them. Built for receive, the serial strobe pushes samples and a data-register read pops them.

The usable depth depends on two settings: a storage-size parameter and the configured channel count. The depth is counted in frames, where one frame holds one sample per channel. The block first rounds the channel count up to a power of two and then divides the storage by it, so three channels and five to seven channels leave part of the storage unused. Status reports how many whole frames are buffered and holds sticky overrun and underrun flags. A half-level request tells software when to service the FIFO. A single control write empties the FIFO at once. Change the channel count only while the FIFO is empty, then clear it.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the status register and the control register both read 0, and the request output `halfIrq` is low.
- R2: The depth in frames is (256 << SIZE_CODE) shifted right by the number of doublings needed to reach the channel count: 1 channel gives 0 doublings, 2 gives 1, 3–4 give 2, 5–8 give 3. A count of 0 is treated as 1 and a count above 8 as 8. The FIFO is full once it holds depth × channels words.
- R3: Status bits [16:8] hold the number of complete frames buffered, that is floor(words / channels). All status bits not named in R3, R5 and R6 read 0.
- R4: Words leave in the order they entered. Only bits [23:0] of a written data word are kept, and a data-register read returns bits [31:24] as 0.
- R5: A push into a full FIFO is dropped, leaves the level unchanged and sets the sticky overrun flag in status bit 4.
- R6: A pop from an empty FIFO returns 0, leaves the level unchanged and sets the sticky underrun flag in status bit 0.
- R7: A status write clears each flag whose bit in the written word is 0. If an error occurs in the same cycle as the clearing write, the flag is set.
- R8: Writing control bit 0 empties the FIFO by the next cycle. Any push or pop in that same cycle is discarded. Control bit 0 always reads 0. Control bit 20 is stored and reads back.
- R9: `halfIrq` equals control bit 20 ANDed with the level condition, and follows the level continuously. The level condition is level ≤ depth/2 for transmit (IS_RX=0) and level ≥ depth/2 for receive (IS_RX=1).
- R10: A push and a pop in the same cycle, on a FIFO that is neither full nor empty, leave the level unchanged.
- R11: The register address is 0 for control, 1 for status and 2 for data, and address 3 reads 0. For transmit, data writes push and `serStrobe` pops onto `serDataOut`. For receive, `serStrobe` pushes `serDataIn` and data reads pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanCount | input | 4 | Configured channel count |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of data pops in receive) |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| serStrobe | input | 1 | Serial-side sample strobe |
| serDataIn | input | 24 | Sample from the serial side (receive) |
| serDataOut | output | 24 | Sample to the serial side (transmit) |
| halfIrq | output | 1 | Half-level service request |

## Verification
Two pairs of functions can fall in the same cycle. An underrun from a serial pop on an empty transmit FIFO can coincide with a status write of zero, and the flag must read back as set. A receive serial push can coincide with a control write that clears the FIFO, and the level must read back as zero. Both cases are provoked by driving the serial strobe and the register write in the same clock cycle. The sweep also covers channel counts 0 through 9. For each count it fills the FIFO to full, checks the frame level and request after every word, and then drains it to confirm order and the zero returned on an empty pop.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int BASE_WORDS     = 256;
  localparam int SAMPLE_W       = 24;
  localparam int CTRL_CLR_BIT   = 0;
  localparam int CTRL_HALF_BIT  = 20;
  localparam int STAT_UNDER_BIT = 0;
  localparam int STAT_OVER_BIT  = 4;
  localparam int STAT_LVL_W     = 9;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifo_strobe_t;
endpackage

// File: rtl/audio_fifo_datapath.sv
module audio_fifo_datapath
  import audio_fifo_pkg::*;
#(
  parameter int RAM_WORDS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifo_strobe_t        strobes,
  input  logic [SAMPLE_W-1:0] pushData,
  output logic [SAMPLE_W-1:0] headData
);
  localparam int PTR_W = $clog2(RAM_WORDS);

  logic [SAMPLE_W-1:0] mem [RAM_WORDS];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headData = mem[rdPtr];

  // R8
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (wrPtr == '0) && (rdPtr == '0));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !strobes.clear) |=> wrPtr == $past(wrPtr) + 1'b1);
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
  import audio_fifo_pkg::*;
#(
  parameter int RAM_WORDS = 256,
  parameter int IS_RX     = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          chanCount,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                serStrobe,
  input  logic [SAMPLE_W-1:0] serDataIn,
  output logic [SAMPLE_W-1:0] serDataOut,
  output logic                halfIrq,
  output fifo_strobe_t        strobes,
  output logic [SAMPLE_W-1:0] pushData,
  input  logic [SAMPLE_W-1:0] headData
);
  localparam int LVL_W = $clog2(RAM_WORDS) + 1;
  localparam logic RX  = (IS_RX != 0);

  logic [3:0]       chEff;
  logic [2:0]       chMinus1;
  logic [1:0]       shiftAmt;
  logic [LVL_W-1:0] depth, halfDepth, frameLvl;
  logic [2:0]       remCnt;
  logic             full, empty, halfCond;
  logic             dataSel, ctrlWr, statWr, clr;
  logic             pushReq, popReq, ovSet, unSet;
  logic             overrun, underrun, halfEn;
  logic [STAT_LVL_W-1:0] statLvl;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWrData;

  always_comb begin
    if (chanCount == 4'd0)     chEff = 4'd1;
    else if (chanCount > 4'd8) chEff = 4'd8;
    else                       chEff = chanCount;
    if (chEff <= 4'd1)      shiftAmt = 2'd0;
    else if (chEff <= 4'd2) shiftAmt = 2'd1;
    else if (chEff <= 4'd4) shiftAmt = 2'd2;
    else                    shiftAmt = 2'd3;
  end

  assign chMinus1  = 3'(chEff - 4'd1);
  assign depth     = LVL_W'(RAM_WORDS) >> shiftAmt;
  assign halfDepth = depth >> 1;
  assign full      = (frameLvl == depth);
  assign empty     = (frameLvl == '0) && (remCnt == 3'd0);

  assign dataSel = (regAddr == ADDR_DATA);
  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);
  assign statWr  = regWrEn && (regAddr == ADDR_STAT);
  assign clr     = ctrlWr && regWrData[CTRL_CLR_BIT];

  assign pushReq = RX ? serStrobe : (regWrEn && dataSel);
  assign popReq  = RX ? (regRdEn && dataSel) : serStrobe;
  assign ovSet   = pushReq && full;
  assign unSet   = popReq && empty;

  assign strobes.push  = pushReq && !full && !clr;
  assign strobes.pop   = popReq && !empty && !clr;
  assign strobes.clear = clr;
  assign pushData      = RX ? serDataIn : regWrData[SAMPLE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      frameLvl <= '0;
      remCnt   <= 3'd0;
    end else if (strobes.push && !strobes.pop) begin
      if (remCnt == chMinus1) begin
        frameLvl <= frameLvl + 1'b1;
        remCnt   <= 3'd0;
      end else begin
        remCnt <= remCnt + 3'd1;
      end
    end else if (strobes.pop && !strobes.push) begin
      if (remCnt == 3'd0) begin
        frameLvl <= frameLvl - 1'b1;
        remCnt   <= chMinus1;
      end else begin
        remCnt <= remCnt - 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrun  <= 1'b0;
      underrun <= 1'b0;
      halfEn   <= 1'b0;
    end else begin
      if (ovSet)       overrun <= 1'b1;
      else if (statWr) overrun <= overrun & regWrData[STAT_OVER_BIT];
      if (unSet)       underrun <= 1'b1;
      else if (statWr) underrun <= underrun & regWrData[STAT_UNDER_BIT];
      if (ctrlWr)      halfEn <= regWrData[CTRL_HALF_BIT];
    end
  end

  generate
    if (IS_RX != 0) begin : g_rx_half
      assign halfCond = (frameLvl >= halfDepth);
    end else begin : g_tx_half
      assign halfCond = (frameLvl <= halfDepth);
    end
  endgenerate

  assign halfIrq = halfEn && halfCond;
  assign statLvl = STAT_LVL_W'(frameLvl);

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = {11'b0, halfEn, 20'b0};
      ADDR_STAT: regRdData = {15'b0, statLvl, 3'b0, overrun, 3'b0, underrun};
      ADDR_DATA: regRdData = (RX && !empty) ? {8'b0, headData} : 32'b0;
      default:   regRdData = 32'b0;
    endcase
  end

  assign serDataOut = (!RX && !empty) ? headData : '0;

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameLvl <= depth) && (remCnt <= chMinus1));
  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && full) |=> overrun);
  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty) |=> underrun);
  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> empty);
  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && strobes.pop) |=> $stable(frameLvl) && $stable(remCnt));
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import audio_fifo_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  parameter int IS_RX     = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  chanCount,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        serStrobe,
  input  logic [23:0] serDataIn,
  output logic [23:0] serDataOut,
  output logic        halfIrq
);
  localparam int RAM_WORDS = BASE_WORDS << SIZE_CODE;

  fifo_strobe_t        strobes;
  logic [SAMPLE_W-1:0] pushData;
  logic [SAMPLE_W-1:0] headData;

  audio_fifo_ctrl #(.RAM_WORDS(RAM_WORDS), .IS_RX(IS_RX)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanCount(chanCount),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .serStrobe(serStrobe), .serDataIn(serDataIn), .serDataOut(serDataOut),
    .halfIrq(halfIrq), .strobes(strobes), .pushData(pushData),
    .headData(headData)
  );

  audio_fifo_datapath #(.RAM_WORDS(RAM_WORDS)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pushData(pushData), .headData(headData)
  );
endmodule

// File: tb/audio_sample_fifo_test.sv
`timescale 1ns/1ps
module audio_sample_fifo_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  chan = 4'd1;
  logic        wrEn = 0, rdEn = 0, ser = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [23:0] sin = 0, sout;
  logic        irq;

  logic [3:0]  rxChan = 4'd2;
  logic        rxWrEn = 0, rxRdEn = 0, rxSer = 0;
  logic [1:0]  rxAddr = 0;
  logic [31:0] rxWdata = 0, rxRdata;
  logic [23:0] rxSin = 0, rxSout;
  logic        rxIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  audio_sample_fifo #(.SIZE_CODE(0), .IS_RX(0)) uut (
    .clk(clk), .rstN(rstN), .chanCount(chan), .regWrEn(wrEn), .regRdEn(rdEn),
    .regAddr(addr), .regWrData(wdata), .regRdData(rdata), .serStrobe(ser),
    .serDataIn(sin), .serDataOut(sout), .halfIrq(irq));

  audio_sample_fifo #(.SIZE_CODE(0), .IS_RX(1)) uutRx (
    .clk(clk), .rstN(rstN), .chanCount(rxChan), .regWrEn(rxWrEn), .regRdEn(rxRdEn),
    .regAddr(rxAddr), .regWrData(rxWdata), .regRdData(rxRdata), .serStrobe(rxSer),
    .serDataIn(rxSin), .serDataOut(rxSout), .halfIrq(rxIrq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wdata = d;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic cpuRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1; addr = a; #1 d = rdata;
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic serTick(output logic [23:0] d);
    @(negedge clk); ser = 1; #1 d = sout;
    @(posedge clk); #1 ser = 0;
  endtask

  task automatic rxWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); rxWrEn = 1; rxAddr = a; rxWdata = d;
    @(posedge clk); #1 rxWrEn = 0;
  endtask

  task automatic rxRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rxRdEn = 1; rxAddr = a; #1 d = rxRdata;
    @(posedge clk); #1 rxRdEn = 0;
  endtask

  task automatic rxPush(input logic [23:0] d);
    @(negedge clk); rxSer = 1; rxSin = d;
    @(posedge clk); #1 rxSer = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [23:0] d;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    cpuRead(2'd1, s); check("R1 status", s, 0);
    cpuRead(2'd0, s); check("R1 ctrl", s, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R11 unmapped address
    cpuRead(2'd3, s); check("R11 addr3", s, 0);

    for (int ch = 0; ch <= 9; ch++) begin
      int e, dep, total, n;
      e = (ch == 0) ? 1 : ((ch > 8) ? 8 : ch);
      dep = 256;
      for (int i = 1; i < e; i <<= 1) dep >>= 1;
      total = dep * e;
      chan = 4'(ch);
      cpuWrite(2'd0, (32'd1 << 20) | 32'd1);
      // R8 control readback
      cpuRead(2'd0, s); check("R8 ctrl readback", s, 32'd1 << 20);
      for (n = 1; n <= total; n++) begin
        cpuWrite(2'd2, {8'hA5, 24'(n + ch * 1000)});
        cpuRead(2'd1, s);
        check("R3 level", s, 32'(n / e) << 8);
        check("R9 tx irq", {31'b0, irq}, {31'b0, ((n / e) <= dep / 2)});
      end
      // R2 full at depth*channels, R5 overrun
      cpuWrite(2'd2, 32'h00FFFFFF);
      cpuRead(2'd1, s); check("R5 overrun", s, (32'(dep) << 8) | 32'h10);
      // R7 clear flags
      cpuWrite(2'd1, 32'd0);
      cpuRead(2'd1, s); check("R7 flag clear", s, 32'(dep) << 8);
      // R4 order and 24-bit storage
      for (n = 1; n <= total; n++) begin
        serTick(d);
        check("R4 tx order", {8'b0, d}, {8'b0, 24'(n + ch * 1000)});
      end
      // R6 empty pop
      serTick(d); check("R6 empty data", {8'b0, d}, 0);
      cpuRead(2'd1, s); check("R6 underrun", s, 32'h1);
      cpuWrite(2'd1, 32'd0);
    end

    // R7 underrun and status clear in the same cycle: set wins
    @(negedge clk); ser = 1; wrEn = 1; addr = 2'd1; wdata = 0;
    @(posedge clk); #1 ser = 0; wrEn = 0;
    cpuRead(2'd1, s); check("R7 set wins", s, 32'h1);
    cpuWrite(2'd1, 32'd0);

    // R10 simultaneous push and pop
    chan = 4'd1;
    cpuWrite(2'd0, 32'd1);
    cpuWrite(2'd2, 32'h11); cpuWrite(2'd2, 32'h22); cpuWrite(2'd2, 32'h33);
    @(negedge clk); wrEn = 1; addr = 2'd2; wdata = 32'h44; ser = 1; #1 d = sout;
    @(posedge clk); #1 wrEn = 0; ser = 0;
    check("R10 head", {8'b0, d}, 32'h11);
    cpuRead(2'd1, s); check("R10 level", s, 32'd3 << 8);
    serTick(d); check("R10 order", {8'b0, d}, 32'h22);

    // receive instance, 2 channels, depth 128 frames
    rxWrite(2'd0, (32'd1 << 20) | 32'd1);
    for (int n = 1; n <= 256; n++) begin
      rxPush(24'(n * 3));
      rxRead(2'd1, s);
      check("R3 rx level", s, 32'(n / 2) << 8);
      check("R9 rx irq", {31'b0, rxIrq}, {31'b0, ((n / 2) >= 64)});
    end
    rxPush(24'hABCDEF);
    rxRead(2'd1, s); check("R5 rx overrun", s, (32'd128 << 8) | 32'h10);
    for (int n = 1; n <= 256; n++) begin
      rxRead(2'd2, s); check("R11 rx data read", s, 32'(n * 3));
    end
    rxRead(2'd2, s); check("R6 rx empty read", s, 0);
    rxRead(2'd1, s); check("R6 rx underrun", s, (32'd1 << 4) | 32'h1);

    // R8 clear with concurrent push
    rxPush(24'h1); rxPush(24'h2); rxPush(24'h3); rxPush(24'h4);
    @(negedge clk); rxSer = 1; rxSin = 24'h5; rxWrEn = 1; rxAddr = 2'd0; rxWdata = 32'd1;
    @(posedge clk); #1 rxSer = 0; rxWrEn = 0;
    rxRead(2'd1, s); check("R8 clear level", s & 32'h1FF00, 0);
    rxRead(2'd2, s); check("R8 clear empty read", s, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule